// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block sits next to a UART-style serial port and converts the port's status flags into interrupt request lines and DMA trigger requests. The serial core pulses set strobes for six flags: transmit buffer empty, transmission finished, receive buffer full, and three receive error conditions (overrun, parity, framing). The block keeps the flags and gates them with per-source enable bits. It drives four request lines: receive error, receive full, transmit empty and transmit end. A fixed-priority encoder reports which pending request is the most urgent.

Software clears flags through a simple write port, in which a 0 written to a bit clears that flag. When the DMA engine acknowledges a transmit-empty or receive-full transfer, the matching flag clears without any software write. A parameter removes DMA triggering from a channel instance. All three error conditions share one request line. If software clears both transmit flags in a single write, no transmit-end request follows until the serial core sets that flag again.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset the flag vector `flags_o` reads 6'b000011. Bit map: [0] transmit empty, [1] transmit end, [2] receive full, [3] overrun, [4] parity, [5] framing. With all enables at 0, no request is raised.
- R2: `irq_o[2]` (transmit empty) is 1 exactly while flag [0] and `en_i[2]` are both 1. `irq_o[1]` (receive full) is 1 exactly while flag [2] and `en_i[1]` are both 1.
- R3: `irq_o[3]` (transmit end) is 1 only while flag [1] is 1 and `en_i[3]` is 1.
- R4: `irq_o[0]` (receive error) is 1 while `en_i[0]` is 1 and any of flags [3], [4] or [5] is 1.
- R5: A write with `wr_en_i`=1 clears, at the next clock edge, every flag whose `wr_data_i` bit is 0. Flags whose bit is 1 are left unchanged.
- R6: A set strobe `core_set_i[k]` makes flag k equal to 1 at the next edge. This holds even if a software clear or a DMA acknowledge targets the same flag in the same cycle.
- R7: With DMA_EN=1, `dma_tx_req_o` equals `irq_o[2]` and `dma_rx_req_o` equals `irq_o[1]`. The error and end sources never drive a DMA request. With DMA_EN=0, both DMA outputs stay 0.
- R8: With DMA_EN=1, `dma_tx_ack_i` clears flag [0] and `dma_rx_ack_i` clears flag [2] at the next edge, and no other flag changes. With DMA_EN=0, the acknowledges have no effect.
- R9: `top_vld_o` is 1 when any `irq_o` bit is 1. `top_idx_o` gives the lowest pending index, so the order from highest to lowest priority is receive error (0), receive full (1), transmit empty (2), transmit end (3). When transmit empty and transmit end are pending together, transmit empty wins.
- R10: A single write that clears flags [0] and [1] together leaves `irq_o[3]` at 0 in every later cycle, until `core_set_i[1]` sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_set_i | input | 6 | Set strobes from the serial core, one per flag (bit map as in R1) |
| wr_en_i | input | 1 | Software write strobe for the flag vector |
| wr_data_i | input | 6 | Write data; a 0 bit clears the flag, a 1 bit keeps it |
| en_i | input | 4 | Per-source enables, indexed by request number |
| dma_tx_ack_i | input | 1 | DMA acknowledge of a transmit-empty transfer |
| dma_rx_ack_i | input | 1 | DMA acknowledge of a receive-full transfer |
| flags_o | output | 6 | Current flag vector |
| irq_o | output | 4 | Request lines: 0 error, 1 receive full, 2 transmit empty, 3 transmit end |
| dma_tx_req_o | output | 1 | DMA trigger for transmit empty |
| dma_rx_req_o | output | 1 | DMA trigger for receive full |
| top_idx_o | output | 2 | Index of the highest-priority pending request |
| top_vld_o | output | 1 | Any request pending |

## Verification
The hardest case to reach is a collision in one cycle: a set strobe from the core arrives together with a software clear or a DMA acknowledge of the same flag. The bench builds this case by driving both on the same negative edge, and then reads the flag vector after the following rising edge. The transmit-end suppression case is reached by enabling both transmit sources while their flags sit at their reset value of 1, then issuing a single write that clears both. The bench watches `irq_o[3]` over several idle cycles before it sets the flag again. A second instance built without DMA sees the same acknowledge stimulus, and the bench confirms that instance's flags do not move.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    // flag vector layout
    localparam int NFLAG     = 6;
    localparam int FLAG_TXE  = 0;
    localparam int FLAG_TEND = 1;
    localparam int FLAG_RXF  = 2;
    localparam int FLAG_OVR  = 3;
    localparam int FLAG_PAR  = 4;
    localparam int FLAG_FRM  = 5;

    // request lines, index order is also priority order (0 = highest)
    localparam int NSRC     = 4;
    localparam int SRC_ERR  = 0;
    localparam int SRC_RXF  = 1;
    localparam int SRC_TXE  = 2;
    localparam int SRC_TEND = 3;
    localparam int SRC_W    = $clog2(NSRC);

    // idle flag state: transmitter empty and finished
    localparam logic [NFLAG-1:0] FLAG_RST =
        (NFLAG'(1) << FLAG_TXE) | (NFLAG'(1) << FLAG_TEND);

    typedef logic [NFLAG-1:0] flag_vec_t;
    typedef logic [NSRC-1:0]  src_vec_t;

endpackage

// File: rtl/sio_flag_bank.sv
module sio_flag_bank #(
    parameter int              NF      = 6,
    parameter logic [NF-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          wr_en_i,
    input  logic [NF-1:0] wr_data_i,
    input  logic [NF-1:0] ack_i,
    output logic [NF-1:0] flags_o
);

    typedef struct packed {
        logic          alive;
        logic [NF-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [NF-1:0] keep_d;

    always_comb begin
        st_d       = st_q;
        keep_d     = wr_en_i ? wr_data_i : '1;
        // set strobe wins over any clear source
        st_d.flags = set_i | (st_q.flags & keep_d & ~ack_i);
        st_d.alive = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.alive <= 1'b0;
            st_q.flags <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.alive |=> ((st_q.flags & $past(set_i)) == $past(set_i))); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.alive |=> ((st_q.flags & $past(ack_i & ~set_i)) == '0)); // R8

endmodule

// File: rtl/sio_req_gen.sv
module sio_req_gen
    import sio_irq_pkg::*;
#(
    parameter bit DMA_EN = 1'b1
) (
    input  flag_vec_t flags_i,
    input  src_vec_t  en_i,
    input  logic      dma_tx_ack_i,
    input  logic      dma_rx_ack_i,
    output src_vec_t  irq_o,
    output logic      dma_tx_req_o,
    output logic      dma_rx_req_o,
    output flag_vec_t ack_o
);

    logic err_any;

    always_comb begin
        err_any         = flags_i[FLAG_OVR] | flags_i[FLAG_PAR] | flags_i[FLAG_FRM];
        irq_o           = '0;
        irq_o[SRC_ERR]  = en_i[SRC_ERR]  & err_any;
        irq_o[SRC_RXF]  = en_i[SRC_RXF]  & flags_i[FLAG_RXF];
        irq_o[SRC_TXE]  = en_i[SRC_TXE]  & flags_i[FLAG_TXE];
        irq_o[SRC_TEND] = en_i[SRC_TEND] & flags_i[FLAG_TEND];
    end

    generate
        if (DMA_EN) begin : g_dma
            assign dma_tx_req_o = irq_o[SRC_TXE];
            assign dma_rx_req_o = irq_o[SRC_RXF];
            assign ack_o = (NFLAG'(dma_tx_ack_i) << FLAG_TXE)
                         | (NFLAG'(dma_rx_ack_i) << FLAG_RXF);
        end else begin : g_nodma
            // acknowledges are gated off; fold them into a zero term
            assign dma_tx_req_o = 1'b0;
            assign dma_rx_req_o = 1'b0;
            assign ack_o = NFLAG'(dma_tx_ack_i & dma_rx_ack_i & 1'b0);
        end
    endgenerate

endmodule

// File: rtl/sio_prio_enc.sv
module sio_prio_enc #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);

    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        // scan downward so the lowest index is the last one kept
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
    import sio_irq_pkg::*;
#(
    parameter bit DMA_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] core_set_i,
    input  logic             wr_en_i,
    input  logic [NFLAG-1:0] wr_data_i,
    input  logic [NSRC-1:0]  en_i,
    input  logic             dma_tx_ack_i,
    input  logic             dma_rx_ack_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [NSRC-1:0]  irq_o,
    output logic             dma_tx_req_o,
    output logic             dma_rx_req_o,
    output logic [SRC_W-1:0] top_idx_o,
    output logic             top_vld_o
);

    flag_vec_t ack_vec;
    flag_vec_t flags_w;
    src_vec_t  irq_w;

    sio_flag_bank #(
        .NF      (NFLAG),
        .RST_VAL (FLAG_RST)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (core_set_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ack_i     (ack_vec),
        .flags_o   (flags_w)
    );

    sio_req_gen #(
        .DMA_EN (DMA_EN)
    ) u_req (
        .flags_i      (flags_w),
        .en_i         (en_i),
        .dma_tx_ack_i (dma_tx_ack_i),
        .dma_rx_ack_i (dma_rx_ack_i),
        .irq_o        (irq_w),
        .dma_tx_req_o (dma_tx_req_o),
        .dma_rx_req_o (dma_rx_req_o),
        .ack_o        (ack_vec)
    );

    sio_prio_enc #(
        .N (NSRC)
    ) u_prio (
        .req_i (irq_w),
        .idx_o (top_idx_o),
        .vld_o (top_vld_o)
    );

    assign flags_o = flags_w;
    assign irq_o   = irq_w;

    logic [NSRC-1:0] higher_mask;
    assign higher_mask = (NSRC'(1) << top_idx_o) - NSRC'(1);

    AST_PRIO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o |-> (irq_w[top_idx_o] && ((irq_w & higher_mask) == '0))); // R9

    AST_TEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_w[SRC_TEND] |-> flags_w[FLAG_TEND]); // R3

    AST_ERR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_w[SRC_ERR] |-> (flags_w[FLAG_OVR] || flags_w[FLAG_PAR] || flags_w[FLAG_FRM])); // R4

    AST_DMA_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx_req_o |-> irq_w[SRC_TXE]) and (dma_rx_req_o |-> irq_w[SRC_RXF])); // R7

endmodule

// File: tb/tb_sio_irq_ctrl.sv
module tb_sio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] core_set = '0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '1;
    logic [3:0] en = '0;
    logic       ack_tx = 1'b0;
    logic       ack_rx = 1'b0;

    logic [5:0] flags, nd_flags;
    logic [3:0] irq, nd_irq;
    logic       dma_tx, dma_rx, nd_dma_tx, nd_dma_rx;
    logic [1:0] idx, nd_idx;
    logic       vld, nd_vld;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sio_irq_ctrl #(.DMA_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .core_set_i(core_set), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .en_i(en), .dma_tx_ack_i(ack_tx), .dma_rx_ack_i(ack_rx),
        .flags_o(flags), .irq_o(irq), .dma_tx_req_o(dma_tx), .dma_rx_req_o(dma_rx),
        .top_idx_o(idx), .top_vld_o(vld));

    sio_irq_ctrl #(.DMA_EN(1'b0)) dut_nodma (
        .clk(clk), .rst_n(rst_n), .core_set_i(core_set), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .en_i(en), .dma_tx_ack_i(ack_tx), .dma_rx_ack_i(ack_rx),
        .flags_o(nd_flags), .irq_o(nd_irq), .dma_tx_req_o(nd_dma_tx), .dma_rx_req_o(nd_dma_rx),
        .top_idx_o(nd_idx), .top_vld_o(nd_vld));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_set(input logic [5:0] v);
        core_set = v; tick(); core_set = '0;
    endtask

    task automatic sw_write(input logic [5:0] v);
        wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0; wr_data = '1;
    endtask

    task automatic t_reset();
        chk("R1 flags", 8'(flags), 8'h03);
        chk("R1 irq", 8'(irq), 8'h0);
        chk("R9 vld idle", 8'(vld), 8'h0);
    endtask

    task automatic t_txempty();
        en = 4'b0100; tick();
        chk("R2 txe irq", 8'(irq), 8'h4);
        chk("R7 dma_tx", 8'(dma_tx), 8'h1);
        chk("R7 nodma tx", 8'(nd_dma_tx), 8'h0);
        en = 4'b0000; tick();
        chk("R2 txe disabled", 8'(irq), 8'h0);
    endtask

    task automatic t_clear();
        en = 4'b0100;
        sw_write(6'b111110);
        chk("R5 clear txe", 8'(flags), 8'h02);
        chk("R2 txe gone", 8'(irq), 8'h0);
        sw_write(6'b111111);
        chk("R5 ones keep", 8'(flags), 8'h02);
    endtask

    task automatic t_rxfull();
        en = 4'b0010;
        pulse_set(6'b000100);
        chk("R2 rxf flag", 8'(flags), 8'h06);
        chk("R2 rxf irq", 8'(irq), 8'h2);
        chk("R7 dma_rx", 8'(dma_rx), 8'h1);
        chk("R7 nodma rx", 8'(nd_dma_rx), 8'h0);
        ack_rx = 1'b1; tick(); ack_rx = 1'b0;
        chk("R8 ack clears rxf only", 8'(flags), 8'h02);
        chk("R8 nodma ack ignored", 8'(nd_flags[2]), 8'h1);
        chk("R7 dma_rx drops", 8'(dma_rx), 8'h0);
    endtask

    task automatic t_errors();
        en = 4'b0001;
        for (int b = 3; b <= 5; b++) begin
            pulse_set(6'(1) << b);
            chk("R4 error irq", 8'(irq), 8'h1);
            chk("R7 no dma on error", 8'({dma_tx, dma_rx}), 8'h0);
            sw_write(~(6'(1) << b));
            chk("R4 error cleared", 8'(irq), 8'h0);
        end
        en = 4'b0000;
        pulse_set(6'b111000);
        chk("R4 error masked", 8'(irq), 8'h0);
        sw_write(6'b000111);
    endtask

    task automatic t_txend();
        en = 4'b1000; tick();
        chk("R3 tend irq", 8'(irq), 8'h8);
        chk("R7 no dma on tend", 8'({dma_tx, dma_rx}), 8'h0);
        en = 4'b0000; tick();
        chk("R3 tend needs enable", 8'(irq), 8'h0);
    endtask

    task automatic t_prio();
        en = 4'b1111;
        pulse_set(6'b111111);
        chk("R9 idx err", 8'({vld, idx}), 8'h4);
        sw_write(6'b000111);
        chk("R9 idx rxf", 8'({vld, idx}), 8'h5);
        ack_rx = 1'b1; tick(); ack_rx = 1'b0;
        chk("R9 txe over tend", 8'({vld, idx}), 8'h6);
        ack_tx = 1'b1; tick(); ack_tx = 1'b0;
        chk("R8 ack clears txe", 8'(flags), 8'h02);
        chk("R9 idx tend", 8'({vld, idx}), 8'h7);
        en = 4'b0000; tick();
    endtask

    task automatic t_collide();
        wr_en = 1'b1; wr_data = 6'b111110; core_set = 6'b000001;
        tick();
        wr_en = 1'b0; wr_data = '1; core_set = '0;
        chk("R6 set beats clear", 8'(flags[0]), 8'h1);
        core_set = 6'b000100; ack_rx = 1'b1; tick();
        core_set = '0; ack_rx = 1'b0;
        chk("R6 set beats ack", 8'(flags[2]), 8'h1);
        sw_write(6'b111011);
    endtask

    task automatic t_both_clear();
        pulse_set(6'b000011);
        en = 4'b1100; tick();
        chk("R10 both pending", 8'(irq), 8'hC);
        sw_write(6'b111100);
        chk("R10 no tend after clear", 8'(irq), 8'h0);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 tend stays off", 8'(irq[3]), 8'h0);
        end
        pulse_set(6'b000010);
        chk("R10 tend after core set", 8'(irq), 8'h8);
        en = 4'b0000;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<5000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_txempty();
        t_clear();
        t_rxfull();
        t_errors();
        t_txend();
        t_prio();
        t_collide();
        t_both_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule